// File: doc/BRIEF.md
# ACPI Embedded Controller Host Interface

This block is the host-facing mailbox between an operating system driver and embedded controller firmware. It follows the classic keyboard-controller style. The host sees two byte-wide run-time ports. A data port sits at a programmable base address, and a command/status port sits four addresses above it. Both host command writes and host data writes land in one input buffer. A flag in the status register records which port the last write used. Host data reads return an output buffer that firmware fills.

A small configuration register set holds an enable bit and the two bytes of the base address. Host decoding stays off until software sets the enable bit. The firmware side can drain the input buffer, fill the output buffer and see both full flags. Firmware can also raise and lower an SCI event request line.

Top module: `acpi_ec_host_if`

## Requirements
- R1: After reset, the enable register, both base bytes, the input and output buffers, the status byte and `sci_o` are all 0.
- R2: Configuration writes to offset 0x30 (enable, bit 0 only), 0x60 (base high byte) and 0x61 (base low byte) read back through `cfg_rdata_o`. Bits 7:1 of 0x30 read 0, and any other offset reads 0.
- R3: While the enable bit is 0, `host_hit_o` stays 0 and host accesses change no buffer or flag.
- R4: While enabled, the decode base is {0x60 byte, 0x61 byte}. An access hits only at base (data port) or at base+4, taken modulo 2^16 (command/status port).
- R5: A host write that hits loads the input buffer and sets IBF (status bit 1). CMD (status bit 3) becomes 1 for a write to base+4 and 0 for a write to base. IBF and CMD update on the same edge.
- R6: A firmware read strobe `fw_ib_rd_i` clears IBF on the next edge and leaves CMD unchanged. A host write in the same cycle wins, and IBF stays 1.
- R7: A firmware write `fw_ob_we_i` loads the output buffer and sets OBF (status bit 0). A host read of the data port returns the output buffer and clears OBF. If a firmware write falls in the same cycle as that read, the read returns the old byte and OBF stays 1.
- R8: A host read of base+4 returns status {4'b0, CMD, 1'b0, IBF, OBF} and changes no state.
- R9: A host write while IBF is 1, or a firmware write while OBF is 1, overwrites the buffer and leaves the flag at 1.
- R10: `fw_sci_set_i` drives `sci_o` high from the next edge and it stays high until `fw_sci_clr_i`. If both are asserted in the same cycle, set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration register offset |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data (combinational) |
| host_valid_i | input | 1 | Host access request this cycle |
| host_write_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 16 | Host I/O address |
| host_wdata_i | input | 8 | Host write data |
| host_hit_o | output | 1 | Access decoded by this block |
| host_rdata_o | output | 8 | Host read data, valid with host_hit_o |
| fw_ib_rd_i | input | 1 | Firmware consumes input buffer |
| fw_ib_data_o | output | 8 | Input buffer contents |
| fw_cmd_o | output | 1 | Last host write was a command |
| fw_ibf_o | output | 1 | Input buffer full |
| fw_ob_we_i | input | 1 | Firmware output buffer write |
| fw_ob_wdata_i | input | 8 | Output buffer write data |
| fw_obf_o | output | 1 | Output buffer full |
| fw_sci_set_i | input | 1 | Raise SCI event request |
| fw_sci_clr_i | input | 1 | Lower SCI event request |
| sci_o | output | 1 | SCI event request to the host |

## Verification
The checker covers the flag-level rules on every cycle. A write that hits must set IBF. A firmware drain without a competing write must clear IBF. A firmware fill must set OBF. No hit may occur while disabled. A status read alone must leave the flags stable. The SCI line must follow the set and clear strobes. Only the bench scenarios can show the address arithmetic across several bases, including the base+4 wrap at the top of the space. They also cover buffer contents and overwrite order, which byte a colliding read returns, and the exact status byte layout as the host reads it.

// File: rtl/ec_host_pkg.sv
package ec_host_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2 * DW;

  localparam int unsigned ST_OBF = 0;
  localparam int unsigned ST_IBF = 1;
  localparam int unsigned ST_CMD = 3;

  typedef struct packed {
    logic wr_data;
    logic wr_cmd;
    logic rd_data;
    logic rd_stat;
  } host_op_t;
endpackage

// File: rtl/ec_cfg_regs.sv
module ec_cfg_regs #(
  parameter int unsigned DW      = 8,
  parameter int unsigned CFG_AW  = 8,
  parameter logic [7:0]  ACT_OFS = 8'h30,
  parameter logic [7:0]  HI_OFS  = 8'h60,
  parameter logic [7:0]  LO_OFS  = 8'h61,
  localparam int unsigned AW     = 2 * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              active_o,
  output logic [AW-1:0]     base_o
);
  logic          act_q;
  logic [DW-1:0] hi_q, lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      hi_q  <= '0;
      lo_q  <= '0;
    end else if (we_i) begin
      if (addr_i == CFG_AW'(ACT_OFS)) act_q <= wdata_i[0];
      if (addr_i == CFG_AW'(HI_OFS))  hi_q  <= wdata_i;
      if (addr_i == CFG_AW'(LO_OFS))  lo_q  <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CFG_AW'(ACT_OFS))     rdata_o = DW'(act_q);
    else if (addr_i == CFG_AW'(HI_OFS)) rdata_o = hi_q;
    else if (addr_i == CFG_AW'(LO_OFS)) rdata_o = lo_q;
  end

  assign active_o = act_q;
  assign base_o   = {hi_q, lo_q};
endmodule

// File: rtl/ec_host_decode.sv
module ec_host_decode
  import ec_host_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned CMD_OFS = 4
) (
  input  logic          valid_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic          active_i,
  input  logic [AW-1:0] base_i,
  output host_op_t      op_o,
  output logic          hit_o
);
  logic [AW-1:0] cmd_addr;
  logic          sel_data, sel_cmd;

  assign cmd_addr = base_i + AW'(CMD_OFS);  // wraps modulo 2^AW
  assign sel_data = valid_i && active_i && (addr_i == base_i);
  assign sel_cmd  = valid_i && active_i && (addr_i == cmd_addr);

  always_comb begin
    op_o.wr_data = sel_data &&  write_i;
    op_o.wr_cmd  = sel_cmd  &&  write_i;
    op_o.rd_data = sel_data && !write_i;
    op_o.rd_stat = sel_cmd  && !write_i;
  end

  assign hit_o = sel_data || sel_cmd;
endmodule

// File: rtl/ec_mailbox.sv
module ec_mailbox
  import ec_host_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  host_op_t      op_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          ib_rd_i,
  output logic [DW-1:0] ib_data_o,
  output logic          cmd_o,
  output logic          ibf_o,
  input  logic          ob_we_i,
  input  logic [DW-1:0] ob_wdata_i,
  output logic          obf_o,
  input  logic          sci_set_i,
  input  logic          sci_clr_i,
  output logic          sci_o
);
  logic [DW-1:0] ib_q, ob_q, status;
  logic          ibf_q, obf_q, cmd_q, sci_q;
  logic          host_wr;

  assign host_wr = op_i.wr_data || op_i.wr_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ib_q  <= '0;
      ob_q  <= '0;
      ibf_q <= 1'b0;
      obf_q <= 1'b0;
      cmd_q <= 1'b0;
      sci_q <= 1'b0;
    end else begin
      // input side: host set beats firmware drain
      if (host_wr) begin
        ib_q  <= host_wdata_i;
        ibf_q <= 1'b1;
        cmd_q <= op_i.wr_cmd;
      end else if (ib_rd_i) begin
        ibf_q <= 1'b0;
      end
      // output side: firmware fill beats host drain
      if (ob_we_i) begin
        ob_q  <= ob_wdata_i;
        obf_q <= 1'b1;
      end else if (op_i.rd_data) begin
        obf_q <= 1'b0;
      end
      if (sci_set_i)      sci_q <= 1'b1;
      else if (sci_clr_i) sci_q <= 1'b0;
    end
  end

  always_comb begin
    status         = '0;
    status[ST_OBF] = obf_q;
    status[ST_IBF] = ibf_q;
    status[ST_CMD] = cmd_q;
  end

  always_comb begin
    host_rdata_o = '0;
    if (op_i.rd_data)      host_rdata_o = ob_q;
    else if (op_i.rd_stat) host_rdata_o = status;
  end

  assign ib_data_o = ib_q;
  assign cmd_o     = cmd_q;
  assign ibf_o     = ibf_q;
  assign obf_o     = obf_q;
  assign sci_o     = sci_q;
endmodule

// File: rtl/acpi_ec_host_if.sv
module acpi_ec_host_if
  import ec_host_pkg::*;
#(
  parameter int unsigned CMD_OFS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [7:0]    cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  output logic [DW-1:0] cfg_rdata_o,
  input  logic          host_valid_i,
  input  logic          host_write_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic          host_hit_o,
  output logic [DW-1:0] host_rdata_o,
  input  logic          fw_ib_rd_i,
  output logic [DW-1:0] fw_ib_data_o,
  output logic          fw_cmd_o,
  output logic          fw_ibf_o,
  input  logic          fw_ob_we_i,
  input  logic [DW-1:0] fw_ob_wdata_i,
  output logic          fw_obf_o,
  input  logic          fw_sci_set_i,
  input  logic          fw_sci_clr_i,
  output logic          sci_o
);
  logic          active;
  logic [AW-1:0] base;
  host_op_t      op;

  ec_cfg_regs #(.DW(DW), .CFG_AW(8)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .active_o (active),
    .base_o   (base)
  );

  ec_host_decode #(.AW(AW), .CMD_OFS(CMD_OFS)) u_dec (
    .valid_i  (host_valid_i),
    .write_i  (host_write_i),
    .addr_i   (host_addr_i),
    .active_i (active),
    .base_i   (base),
    .op_o     (op),
    .hit_o    (host_hit_o)
  );

  ec_mailbox #(.DW(DW)) u_mbx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_i         (op),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o),
    .ib_rd_i      (fw_ib_rd_i),
    .ib_data_o    (fw_ib_data_o),
    .cmd_o        (fw_cmd_o),
    .ibf_o        (fw_ibf_o),
    .ob_we_i      (fw_ob_we_i),
    .ob_wdata_i   (fw_ob_wdata_i),
    .obf_o        (fw_obf_o),
    .sci_set_i    (fw_sci_set_i),
    .sci_clr_i    (fw_sci_clr_i),
    .sci_o        (sci_o)
  );
endmodule

// File: rtl/ec_host_if_chk.sv
module ec_host_if_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic active,
  input logic host_valid_i,
  input logic host_write_i,
  input logic host_hit_o,
  input logic fw_ib_rd_i,
  input logic fw_ibf_o,
  input logic fw_cmd_o,
  input logic fw_ob_we_i,
  input logic fw_obf_o,
  input logic fw_sci_set_i,
  input logic fw_sci_clr_i,
  input logic sci_o
);
  // R3
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !host_hit_o);

  // R5
  ibf_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_hit_o && host_write_i) |=> fw_ibf_o);

  // R6
  ibf_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fw_ib_rd_i && !(host_hit_o && host_write_i)) |=> !fw_ibf_o);

  // R6
  cmd_kept_on_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_hit_o && host_write_i) |=> $stable(fw_cmd_o));

  // R7
  obf_on_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw_ob_we_i |=> fw_obf_o);

  // R8
  stat_read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_hit_o && !host_write_i && fw_obf_o == 1'b0 && !fw_ib_rd_i && !fw_ob_we_i)
      |=> ($stable(fw_ibf_o) && !fw_obf_o));

  // R10
  sci_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw_sci_set_i |=> sci_o);

  // R10
  sci_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fw_sci_set_i && !fw_sci_clr_i) |=> $stable(sci_o));

  // R10
  sci_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fw_sci_clr_i && !fw_sci_set_i) |=> !sci_o);
endmodule

bind acpi_ec_host_if ec_host_if_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .active       (active),
  .host_valid_i (host_valid_i),
  .host_write_i (host_write_i),
  .host_hit_o   (host_hit_o),
  .fw_ib_rd_i   (fw_ib_rd_i),
  .fw_ibf_o     (fw_ibf_o),
  .fw_cmd_o     (fw_cmd_o),
  .fw_ob_we_i   (fw_ob_we_i),
  .fw_obf_o     (fw_obf_o),
  .fw_sci_set_i (fw_sci_set_i),
  .fw_sci_clr_i (fw_sci_clr_i),
  .sci_o        (sci_o)
);

// File: tb/acpi_ec_host_if_tb_top.sv
module acpi_ec_host_if_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0, cfg_wdata = '0, cfg_rdata;
  logic        h_v = 1'b0, h_w = 1'b0;
  logic [15:0] h_a = '0;
  logic [7:0]  h_wd = '0, h_rd;
  logic        h_hit;
  logic        ib_rd = 1'b0, ob_we = 1'b0, s_set = 1'b0, s_clr = 1'b0;
  logic [7:0]  ob_wd = '0, ib_data;
  logic        cmd, ibf, obf, sci;
  int          checks = 0, failures = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  acpi_ec_host_if dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .host_valid_i(h_v), .host_write_i(h_w), .host_addr_i(h_a), .host_wdata_i(h_wd),
    .host_hit_o(h_hit), .host_rdata_o(h_rd),
    .fw_ib_rd_i(ib_rd), .fw_ib_data_o(ib_data), .fw_cmd_o(cmd), .fw_ibf_o(ibf),
    .fw_ob_we_i(ob_we), .fw_ob_wdata_i(ob_wd), .fw_obf_o(obf),
    .fw_sci_set_i(s_set), .fw_sci_clr_i(s_clr), .sci_o(sci)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); cfg_addr = a; #2 d = cfg_rdata;
  endtask

  // one cycle with any mix of host and firmware strobes; outputs sampled before the edge
  task automatic step(input logic v, input logic w, input logic [15:0] a, input logic [7:0] wd,
                      input logic rd, input logic owe, input logic [7:0] od,
                      input logic ss, input logic sc,
                      output logic hit, output logic [7:0] rdat);
    @(negedge clk);
    h_v = v; h_w = w; h_a = a; h_wd = wd;
    ib_rd = rd; ob_we = owe; ob_wd = od; s_set = ss; s_clr = sc;
    #2 hit = h_hit; rdat = h_rd;
    @(negedge clk);
    h_v = 1'b0; h_w = 1'b0; ib_rd = 1'b0; ob_we = 1'b0; s_set = 1'b0; s_clr = 1'b0;
  endtask

  task automatic status(input logic [15:0] base, output logic [7:0] st);
    logic hit;
    step(1, 0, base + 16'd4, 0, 0, 0, 0, 0, 0, hit, st);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, st;
    logic       hit;
    logic [15:0] bases [3];
    bases[0] = 16'h0062; bases[1] = 16'h1234; bases[2] = 16'hFFFD;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cfg_rd(8'h30, d); check("R1 enable", d, 8'h00);
    cfg_rd(8'h60, d); check("R1 base hi", d, 8'h00);
    cfg_rd(8'h61, d); check("R1 base lo", d, 8'h00);
    check("R1 flags", {ibf, obf, cmd, sci}, 4'b0000);
    check("R1 ib", ib_data, 8'h00);

    // R2 config readback
    cfg_wr(8'h60, 8'h12); cfg_wr(8'h61, 8'h34); cfg_wr(8'h30, 8'hFF);
    cfg_rd(8'h30, d); check("R2 enable bit0 only", d, 8'h01);
    cfg_rd(8'h60, d); check("R2 hi", d, 8'h12);
    cfg_rd(8'h61, d); check("R2 lo", d, 8'h34);
    for (int o = 0; o < 256; o++) begin
      if (o != 8'h30 && o != 8'h60 && o != 8'h61) begin
        cfg_rd(8'(o), d); check("R2 unmapped reads 0", d, 8'h00);
      end
    end

    // R3 disabled: no hit, no state change
    cfg_wr(8'h30, 8'h00);
    step(1, 1, 16'h1234, 8'h99, 0, 0, 0, 0, 0, hit, d);
    check("R3 data wr no hit", hit, 0);
    step(1, 1, 16'h1238, 8'h98, 0, 0, 0, 0, 0, hit, d);
    check("R3 cmd wr no hit", hit, 0);
    check("R3 ibf/cmd untouched", {ibf, cmd}, 2'b00);
    check("R3 ib untouched", ib_data, 8'h00);
    cfg_wr(8'h30, 8'h01);

    // R4 decode sweep: offsets -6..+9 around three bases (last wraps)
    foreach (bases[b]) begin
      cfg_wr(8'h60, bases[b][15:8]); cfg_wr(8'h61, bases[b][7:0]);
      for (int off = -6; off <= 9; off++) begin
        logic [15:0] a;
        a = bases[b] + 16'(off);
        step(1, 0, a, 0, 0, 0, 0, 0, 0, hit, d);
        check("R4 hit map", hit, (off == 0 || off == 4) ? 1'b1 : 1'b0);
      end
    end
    cfg_wr(8'h60, 8'h12); cfg_wr(8'h61, 8'h34);

    // R5 data write then command write
    step(1, 1, 16'h1234, 8'hA5, 0, 0, 0, 0, 0, hit, d);
    check("R5 ib data", ib_data, 8'hA5);
    check("R5 ibf,cmd after data write", {ibf, cmd}, 2'b10);
    status(16'h1234, st); check("R5 status after data write", st, 8'h02);
    // R9 overwrite while full
    step(1, 1, 16'h1238, 8'h5A, 0, 0, 0, 0, 0, hit, d);
    check("R9 ib overwritten", ib_data, 8'h5A);
    check("R5 ibf,cmd after cmd write", {ibf, cmd}, 2'b11);
    status(16'h1234, st); check("R5 status after cmd write", st, 8'h0A);

    // R6 drain keeps CMD; collision keeps IBF
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, hit, d);
    check("R6 ibf cleared", ibf, 0);
    status(16'h1234, st); check("R6 status cmd kept", st, 8'h08);
    step(1, 1, 16'h1234, 8'h3E, 1, 0, 0, 0, 0, hit, d);
    check("R6 write beats drain", {ibf, cmd}, 2'b10);
    check("R6 collision data", ib_data, 8'h3E);
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, hit, d);

    // R7 output buffer
    step(0, 0, 0, 0, 0, 1, 8'h3C, 0, 0, hit, d);
    check("R7 obf set", obf, 1);
    status(16'h1234, st); check("R7 status obf", st, 8'h01);
    step(1, 0, 16'h1234, 0, 0, 0, 0, 0, 0, hit, d);
    check("R7 host read data", d, 8'h3C);
    check("R7 obf cleared", obf, 0);
    step(0, 0, 0, 0, 0, 1, 8'h11, 0, 0, hit, d);
    step(0, 0, 0, 0, 0, 1, 8'h22, 0, 0, hit, d);
    check("R9 obf stays", obf, 1);
    step(1, 0, 16'h1234, 0, 0, 1, 8'h77, 0, 0, hit, d);
    check("R7 collision returns old", d, 8'h22);
    check("R7 fill beats drain", obf, 1);
    step(1, 0, 16'h1234, 0, 0, 0, 0, 0, 0, hit, d);
    check("R7 new byte after collision", d, 8'h77);

    // R8 status read has no side effect
    step(0, 0, 0, 0, 0, 1, 8'h44, 0, 0, hit, d);
    step(1, 1, 16'h1238, 8'h01, 0, 0, 0, 0, 0, hit, d);
    status(16'h1234, st); check("R8 status first", st, 8'h0B);
    status(16'h1234, st); check("R8 status repeat", st, 8'h0B);
    check("R8 flags intact", {ibf, obf, cmd}, 3'b111);

    // R10 SCI
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, hit, d); check("R10 set", sci, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, hit, d); check("R10 hold", sci, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, hit, d); check("R10 clear", sci, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, hit, d); check("R10 set wins", sci, 1);

    // R1 reset again clears everything
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    check("R1 flags after reset", {ibf, obf, cmd, sci}, 4'b0000);
    cfg_rd(8'h30, d); check("R1 enable after reset", d, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule